// File: doc/BRIEF.md
# External-Master Transfer Acknowledge Generator

This block sits on the slave side of a shared bus. It watches bus cycles that an external bus master starts and drives the active-low transfer-acknowledge line that ends each data beat. The master samples the acknowledge on every rising clock edge. It stretches a beat with wait states until it finds the acknowledge asserted. A control bit enables the generator, and a programmed count sets how many wait states each beat carries.

Byte and word accesses finish in one beat. A longword access to a 16-bit port runs as two word beats, and both beats carry their data on the upper half of the data bus. For the second beat the master moves the address up by two. The block reports that address and flags each beat's completion clock, so the port logic can latch or drive each word. After the final beat the block drives the acknowledge to its inactive level for one clock. It then stops driving the pad so that another device can use the line.

Top module: `xm_ack_gen`

## Requirements
- R1: A start with `xm_ack_en_i` low is ignored. `ta_oe_o` stays 0, `ta_no` stays 1 and `beat_done_o` stays 0.
- R2: With enable set and `wait_cnt_i` = 0, `ta_no` goes low in the second clock after the edge that samples `xfer_start_i`. The clock in between is driven high with `ta_oe_o` = 1.
- R3: With `wait_cnt_i` = N, every beat is preceded by N clocks of `ta_no` high, counted from the point where the zero-wait case would assert it.
- R4: `size_i` encodes 00 byte, 01 word, 10 longword and 11 reserved. Every size other than 10 completes in exactly one beat.
- R5: A longword runs two beats. `beat_addr_o` equals the latched start address in the first beat and that address plus two in the second. `beat_last_o` is 1 only in the final beat.
- R6: For a longword with zero wait states, `ta_no` stays low for two consecutive clocks.
- R7: For a longword with N > 0 wait states, `ta_no` returns high for exactly N clocks between the two beats.
- R8: In the clock after the final beat, `ta_no` is 1 and `ta_oe_o` is still 1. In the clock after that, `ta_oe_o` is 0.
- R9: `ta_oe_o` is 0 during reset and whenever no cycle is active. A start that arrives while a cycle is active, including its turnaround clock, is ignored.
- R10: `beat_done_o` is 1 exactly in the clocks where `ta_no` is low.
- R11: Enable, size, wait count and address are captured when the cycle starts. Later changes to them do not affect a running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_start_i | input | 1 | External-master cycle start, sampled on the rising edge |
| addr_i | input | ADDR_W | Start address of the access |
| size_i | input | 2 | Access size (00 byte, 01 word, 10 longword, 11 reserved) |
| xm_ack_en_i | input | 1 | Enables acknowledge generation for external-master cycles |
| wait_cnt_i | input | WAIT_W | Wait states per beat |
| ta_no | output | 1 | Transfer acknowledge, active low |
| ta_oe_o | output | 1 | Output enable for the acknowledge pad |
| beat_done_o | output | 1 | Current clock completes a beat |
| beat_last_o | output | 1 | Current beat is the final beat of the access |
| beat_addr_o | output | ADDR_W | Address of the current beat |

## Verification
Two functions can land in the same clock: the release of the pad at the end of one cycle, and the arrival of a new start. The bench raises `xfer_start_i` in the turnaround clock. It also raises it in the middle of a waited beat, and drops the enable and changes the size while a longword is running. A correct block finishes the running cycle unchanged: the same beat count, addresses and acknowledge timing as without the stray inputs. It then releases the pad and shows no new cycle in the clocks that follow.

// File: rtl/xm_ack_pkg.sv
package xm_ack_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_ACK,
    ST_TURN
  } bus_st_e;
endpackage

// File: rtl/xm_ack_wait_cnt.sv
module xm_ack_wait_cnt #(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] load_val_i,
  input  logic              dec_i,
  output logic              last_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (dec_i && cnt_q != 0) cnt_q <= cnt_q - WAIT_W'(1);
  end

  assign last_o = (cnt_q == WAIT_W'(1));

  // decrement only ever requested on a live count
  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/xm_ack_seq.sv
module xm_ack_seq
  import xm_ack_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              en_i,
  input  logic [1:0]        size_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              last_wait_i,
  output logic              load_o,
  output logic [WAIT_W-1:0] load_val_o,
  output logic              dec_o,
  output bus_st_e           state_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic              beat_last_o
);
  localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

  bus_st_e           state_q, state_d;
  logic              long_q, second_q;
  logic [WAIT_W-1:0] wait_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept, split;

  assign accept = (state_q == ST_IDLE) && start_i && en_i;
  assign split  = (state_q == ST_ACK) && long_q && !second_q;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = wait_q;
    dec_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_ADDR;
      ST_ADDR: begin
        if (wait_q == '0) state_d = ST_ACK;
        else begin
          state_d = ST_WAIT;
          load_o  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (last_wait_i) state_d = ST_ACK;
        else             dec_o   = 1'b1;
      end
      ST_ACK: begin
        if (split) begin
          if (wait_q != '0) begin
            state_d = ST_WAIT;
            load_o  = 1'b1;
          end
        end else begin
          state_d = ST_TURN;
        end
      end
      ST_TURN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      long_q   <= 1'b0;
      second_q <= 1'b0;
      wait_q   <= '0;
      addr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        long_q   <= (size_i == SZ_LONG);
        second_q <= 1'b0;
        wait_q   <= wait_i;
        addr_q   <= addr_i;
      end else if (split) begin
        second_q <= 1'b1;
      end
    end
  end

  assign state_o     = state_q;
  assign beat_last_o = !long_q || second_q;
  assign beat_addr_o = second_q ? addr_q + HALF_STEP : addr_q;

  a_r6_long_zero_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split && wait_q == '0) |=> (state_q == ST_ACK));
  a_r9_busy_ignores_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TURN) |=> (state_q == ST_IDLE));
  a_r11_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_TURN) |=> ($stable(wait_q) && $stable(long_q)));
endmodule

// File: rtl/xm_ack_pad.sv
module xm_ack_pad
  import xm_ack_pkg::*;
(
  input  bus_st_e state_i,
  output logic    ta_no,
  output logic    ta_oe_o,
  output logic    beat_done_o
);
  assign beat_done_o = (state_i == ST_ACK);
  assign ta_no       = !(state_i == ST_ACK);
  assign ta_oe_o     = (state_i != ST_IDLE);
endmodule

// File: rtl/xm_ack_gen.sv
module xm_ack_gen
  import xm_ack_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              xm_ack_en_i,
  input  logic [WAIT_W-1:0] wait_cnt_i,
  output logic              ta_no,
  output logic              ta_oe_o,
  output logic              beat_done_o,
  output logic              beat_last_o,
  output logic [ADDR_W-1:0] beat_addr_o
);
  logic              cnt_load, cnt_dec, cnt_last;
  logic [WAIT_W-1:0] cnt_val;
  bus_st_e           state;

  xm_ack_seq #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (xfer_start_i),
    .en_i        (xm_ack_en_i),
    .size_i      (size_i),
    .wait_i      (wait_cnt_i),
    .addr_i      (addr_i),
    .last_wait_i (cnt_last),
    .load_o      (cnt_load),
    .load_val_o  (cnt_val),
    .dec_o       (cnt_dec),
    .state_o     (state),
    .beat_addr_o (beat_addr_o),
    .beat_last_o (beat_last_o)
  );

  xm_ack_wait_cnt #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .dec_i      (cnt_dec),
    .last_o     (cnt_last)
  );

  xm_ack_pad u_pad (
    .state_i     (state),
    .ta_no       (ta_no),
    .ta_oe_o     (ta_oe_o),
    .beat_done_o (beat_done_o)
  );

  a_r1_disabled_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ta_oe_o && xfer_start_i && !xm_ack_en_i) |=> !ta_oe_o);
  a_r2_start_drives_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ta_oe_o && xfer_start_i && xm_ack_en_i) |=> (ta_oe_o && ta_no));
  a_r8_ta_low_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ta_no |-> ta_oe_o);
  a_r8_release_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ta_oe_o) |-> $past(ta_no));
  a_r5_second_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_done_o && !beat_last_o) |=> (beat_addr_o == $past(beat_addr_o) + ADDR_W'(2)));
  a_r8_last_then_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_done_o && beat_last_o) |=> (ta_oe_o && ta_no));
endmodule

// File: tb/xm_ack_gen_bench.sv
module xm_ack_gen_bench;
  localparam int ADDR_W = 32;
  localparam int WAIT_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [1:0]        size = 2'b00;
  logic              en = 1'b0;
  logic [WAIT_W-1:0] wcnt = '0;
  logic              ta_n, ta_oe, done, last;
  logic [ADDR_W-1:0] baddr;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xm_ack_gen #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_xm_ack_gen (
    .clk_i(clk), .rst_ni(rst_n), .xfer_start_i(start), .addr_i(addr),
    .size_i(size), .xm_ack_en_i(en), .wait_cnt_i(wcnt),
    .ta_no(ta_n), .ta_oe_o(ta_oe), .beat_done_o(done),
    .beat_last_o(last), .beat_addr_o(baddr)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_pins(string req, logic e_oe, logic e_ta, logic e_done);
    chk(req, "ta_oe", 64'(ta_oe), 64'(e_oe));
    chk(req, "ta_n", 64'(ta_n), 64'(e_ta));
    chk("R10", "beat_done", 64'(done), 64'(e_done));
  endtask

  // poke: 0 none, 1 start+cfg change mid-cycle, 2 start in turnaround
  task automatic xfer(string req, logic [1:0] sz, int nw, logic [ADDR_W-1:0] a, int poke);
    int beats;
    beats = (sz == 2'b10) ? 2 : 1;
    @(negedge clk);
    start = 1'b1; en = 1'b1; size = sz; wcnt = WAIT_W'(nw); addr = a;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "C2 drive high", {62'd0, ta_oe, ta_n}, 64'd3);
    if (poke == 1) begin
      start = 1'b1; en = 1'b0; size = 2'b00; wcnt = '0; addr = '0;
    end
    for (int b = 0; b < beats; b++) begin
      for (int w = 0; w < nw; w++) begin
        @(negedge clk);
        start = 1'b0;
        chk(b == 0 ? "R3" : "R7", "wait state", {62'd0, ta_oe, ta_n}, 64'd3);
        chk("R10", "no done in wait", 64'(done), 64'd0);
      end
      @(negedge clk);
      start = 1'b0;
      chk_pins(nw == 0 ? (b == 0 ? "R2" : "R6") : "R3", 1'b1, 1'b0, 1'b1);
      chk("R5", "beat addr", 64'(baddr), 64'(a + ADDR_W'(2 * b)));
      chk(beats == 1 ? "R4" : "R5", "beat last", 64'(last), 64'(b == beats - 1));
    end
    @(negedge clk);
    chk_pins("R8", 1'b1, 1'b1, 1'b0);
    if (poke == 2) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk_pins("R8", 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk_pins(poke != 0 ? "R9" : "R11", 1'b0, 1'b1, 1'b0);
    en = 1'b1;
  endtask

  task automatic t_disabled();
    @(negedge clk);
    en = 1'b0; start = 1'b1; size = 2'b10;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk_pins("R1", 1'b0, 1'b1, 1'b0);
      @(negedge clk);
    end
    en = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2;
    chk_pins("R9", 1'b0, 1'b1, 1'b0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pins("R9", 1'b0, 1'b1, 1'b0);
    t_disabled();
    xfer("R4", 2'b00, 0, 32'h0000_1000, 0);
    xfer("R4", 2'b01, 2, 32'h0000_2002, 0);
    xfer("R4", 2'b11, 1, 32'h0000_3000, 0);
    xfer("R6", 2'b10, 0, 32'h0000_4000, 0);
    xfer("R7", 2'b10, 3, 32'h0000_5004, 0);
    xfer("R11", 2'b10, 2, 32'hFFFF_FFFC, 1);
    xfer("R9", 2'b01, 3, 32'h0000_6000, 1);
    xfer("R9", 2'b10, 0, 32'h0000_7000, 2);
    xfer("R3", 2'b00, 15, 32'h0000_8000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule